// File: doc/BRIEF.md
# Fractional Data-Clock and Frame-Sync Generator

This block derives a serial data clock and a 125 µs frame-sync pulse from a reference clock whose period T does not divide the frame into equal clock periods. It runs on a clock at twice the reference rate (one tick = T/2). Each frame holds 192 data-clock periods. Most are 8.5T long, and a regular sprinkling of 8T periods makes the total exactly 1625T (3250 ticks). The frame-sync output is high for the first 268.5T (537 ticks) of each frame.

A 3-bit mode input either turns generation off or picks an integer divider applied to the base clock. The frame-sync timing never changes with the mode. For timing alignment, two request inputs stretch or shrink twelve consecutive frames by 1T each. The request is taken at a frame boundary. When the sequence finishes, the block pulses a clear strobe that tells the request owner to drop the flag.

Top module: `fclk_frame_gen`

## Requirements
- R1: After reset, and whenever mode code 0 or 7 is applied, `dcl_o`, `fsc_o`, `ext_clr_o` and `red_clr_o` stay low. Requests are ignored while the block is off.
- R2: In mode 1, base period k (0..191) lasts 16 ticks (8 high, 8 low) when k mod 13 = 12, and 17 ticks (9 high, 8 low) otherwise. That gives 192 rising edges per frame.
- R3: A frame lasts 3250 ticks. `fsc_o` rises together with the first rising edge of `dcl_o` in the frame and stays high for 537 ticks.
- R4: Outputs are registered. On the cycle after the first clock edge that samples an enabling mode, the outputs show tick 0 of period 0, so `dcl_o` and `fsc_o` are both high.
- R5: An extend request (`ext_req_i` high) is sampled only on tick 0 of a frame. Once taken, that frame and the next 11 frames each last 3252 ticks, with the extra 2 ticks added to the low phase of period 191.
- R6: A reduce request (`red_req_i` high) follows the same rule as R5, except that each of the 12 frames lasts 3248 ticks, with the low phase of period 191 cut by 2 ticks.
- R7: On tick 0 of the frame after the twelfth adjusted frame, the matching clear strobe is high for exactly one cycle, in the same cycle as the rise of `fsc_o`. Requests are not sampled on that tick.
- R8: If both requests are high at an idle frame start, no adjustment occurs. Both clear strobes pulse together on that frame's first cycle, and the frame stays 3250 ticks long.
- R9: Mode codes 2, 3, 4, 5 and 6 divide the base clock by 2, 3, 4, 6 and 12. `dcl_o` is high during base periods whose index mod N is below ceil(N/2). The frame length and the `fsc_o` timing are unchanged.
- R10: Turning the block off mid-frame drops any adjustment in progress without a clear strobe. Turning it back on restarts at period 0 with a nominal frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Tick clock, twice the reference rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| mode_i | input | 3 | 0/7 off, 1 base clock, 2..6 divided clock |
| ext_req_i | input | 1 | Request to stretch 12 frames by 1T |
| red_req_i | input | 1 | Request to shrink 12 frames by 1T |
| dcl_o | output | 1 | Data clock |
| fsc_o | output | 1 | Frame sync |
| ext_clr_o | output | 1 | One-cycle strobe: extend sequence done |
| red_clr_o | output | 1 | One-cycle strobe: reduce sequence done |

## Verification
A wrong period or segment count shows up within one period as a shifted `dcl_o` edge. It also moves the frame boundary, so the next `fsc_o` rise arrives at the wrong tick. A wrong adjustment count stays hidden until the boundary of the thirteenth frame, where a missing, early or late clear strobe gives it away. An unwanted extra adjusted frame shows up as a 3252- or 3248-tick frame where 3250 is expected. The bench therefore compares every output on every cycle against a behavioural model, and also measures frame lengths, sync-pulse widths and edge counts directly.

// File: rtl/fclk_pkg.sv
package fclk_pkg;

  localparam int unsigned MODE_W      = 3;
  localparam int unsigned MODE_OFF    = 0;
  localparam int unsigned MODE_BASE   = 1;
  localparam int unsigned MODE_DIV_LO = 2;
  localparam int unsigned MODE_EXTERN = 7;

  localparam int unsigned DIV_N = 5;
  localparam int unsigned DIV_RATIO [DIV_N] = '{2, 3, 4, 6, 12};

  typedef enum logic [1:0] {
    ADJ_NONE = 2'd0,
    ADJ_EXT  = 2'd1,
    ADJ_RED  = 2'd2
  } adj_dir_e;

  function automatic logic mode_on(logic [MODE_W-1:0] m);
    return (m != MODE_W'(MODE_OFF)) && (m != MODE_W'(MODE_EXTERN));
  endfunction

endpackage

// File: rtl/fclk_timebase.sv
module fclk_timebase
  import fclk_pkg::*;
#(
  parameter int unsigned PERIODS      = 192,
  parameter int unsigned SHORT_STRIDE = 13,
  parameter int unsigned LOW_HT       = 8,
  parameter int unsigned LONG_HI_HT   = 9,
  parameter int unsigned SHORT_HI_HT  = 8,
  parameter int unsigned FSC_HT       = 537,
  parameter int unsigned ADJ_HT       = 2,
  localparam int unsigned N_SHORT  = PERIODS / SHORT_STRIDE,
  localparam int unsigned FRAME_HT = PERIODS * (LOW_HT + LONG_HI_HT)
                                     - N_SHORT * (LONG_HI_HT - SHORT_HI_HT),
  localparam int unsigned PER_W  = $clog2(PERIODS),
  localparam int unsigned POS_W  = $clog2(LOW_HT + LONG_HI_HT + ADJ_HT + 1),
  localparam int unsigned SEG_W  = $clog2(SHORT_STRIDE),
  localparam int unsigned TICK_W = $clog2(FRAME_HT + ADJ_HT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             en_i,
  input  adj_dir_e         dir_i,
  output logic [PER_W-1:0] per_o,
  output logic             hi_o,
  output logic             fsc_o,
  output logic             frame_start_o
);

  logic [POS_W-1:0]  pos_q;
  logic [PER_W-1:0]  per_q;
  logic [SEG_W-1:0]  seg_q;
  logic [TICK_W-1:0] tick_q;
  logic [POS_W-1:0]  hi_len, per_len;
  logic              short_per, last_per, per_end;

  assign short_per = (seg_q == SEG_W'(SHORT_STRIDE - 1));
  assign last_per  = (per_q == PER_W'(PERIODS - 1));
  assign hi_len    = short_per ? POS_W'(SHORT_HI_HT) : POS_W'(LONG_HI_HT);

  // frame trim lands on the final low phase
  always_comb begin
    per_len = hi_len + POS_W'(LOW_HT);
    if (last_per) begin
      unique case (dir_i)
        ADJ_EXT: per_len = per_len + POS_W'(ADJ_HT);
        ADJ_RED: per_len = per_len - POS_W'(ADJ_HT);
        default: per_len = per_len;
      endcase
    end
  end

  assign per_end = (pos_q == per_len - POS_W'(1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_q  <= '0;
      per_q  <= '0;
      seg_q  <= '0;
      tick_q <= '0;
    end else if (!en_i) begin
      pos_q  <= '0;
      per_q  <= '0;
      seg_q  <= '0;
      tick_q <= '0;
    end else if (per_end) begin
      pos_q <= '0;
      if (last_per) begin
        per_q  <= '0;
        seg_q  <= '0;
        tick_q <= '0;
      end else begin
        per_q  <= per_q + PER_W'(1);
        seg_q  <= short_per ? '0 : seg_q + SEG_W'(1);
        tick_q <= tick_q + TICK_W'(1);
      end
    end else begin
      pos_q  <= pos_q + POS_W'(1);
      tick_q <= tick_q + TICK_W'(1);
    end
  end

  assign per_o         = per_q;
  assign hi_o          = (pos_q < hi_len);
  assign fsc_o         = (tick_q < TICK_W'(FSC_HT));
  assign frame_start_o = en_i && (tick_q == '0);

endmodule

// File: rtl/fclk_adjust.sv
module fclk_adjust
  import fclk_pkg::*;
#(
  parameter int unsigned ADJ_FRAMES = 12,
  localparam int unsigned CNT_W = $clog2(ADJ_FRAMES)
) (
  input  logic     clk_i,
  input  logic     rst_ni,
  input  logic     en_i,
  input  logic     frame_start_i,
  input  logic     ext_req_i,
  input  logic     red_req_i,
  output adj_dir_e dir_o,
  output logic     ext_clr_o,
  output logic     red_clr_o
);

  adj_dir_e         dir_q;
  logic [CNT_W-1:0] left_q;
  logic             ext_clr_q, red_clr_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_q     <= ADJ_NONE;
      left_q    <= '0;
      ext_clr_q <= 1'b0;
      red_clr_q <= 1'b0;
    end else begin
      ext_clr_q <= 1'b0;
      red_clr_q <= 1'b0;
      if (!en_i) begin
        dir_q  <= ADJ_NONE;
        left_q <= '0;
      end else if (frame_start_i) begin
        if (dir_q != ADJ_NONE) begin
          if (left_q == '0) begin
            ext_clr_q <= (dir_q == ADJ_EXT);
            red_clr_q <= (dir_q == ADJ_RED);
            dir_q     <= ADJ_NONE;
          end else begin
            left_q <= left_q - CNT_W'(1);
          end
        end else if (ext_req_i && red_req_i) begin
          ext_clr_q <= 1'b1;   // conflicting pair: drop both
          red_clr_q <= 1'b1;
        end else if (ext_req_i) begin
          dir_q  <= ADJ_EXT;
          left_q <= CNT_W'(ADJ_FRAMES - 1);
        end else if (red_req_i) begin
          dir_q  <= ADJ_RED;
          left_q <= CNT_W'(ADJ_FRAMES - 1);
        end
      end
    end
  end

  assign dir_o     = dir_q;
  assign ext_clr_o = ext_clr_q;
  assign red_clr_o = red_clr_q;

endmodule

// File: rtl/fclk_shaper.sv
module fclk_shaper
  import fclk_pkg::*;
#(
  parameter int unsigned PER_W = 8
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic [MODE_W-1:0] mode_i,
  input  logic [PER_W-1:0]  per_i,
  input  logic              hi_i,
  input  logic              fsc_i,
  output logic              dcl_o,
  output logic              fsc_o
);

  logic [DIV_N-1:0] div_hit;
  logic             dcl_d;

  for (genvar g = 0; g < DIV_N; g++) begin : g_div
    localparam int unsigned RATIO = DIV_RATIO[g];
    assign div_hit[g] = (mode_i == MODE_W'(MODE_DIV_LO + g))
                        && ((32'(per_i) % RATIO) < ((RATIO + 1) / 2));
  end

  assign dcl_d = (mode_i == MODE_W'(MODE_BASE)) ? hi_i : |div_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dcl_o <= 1'b0;
      fsc_o <= 1'b0;
    end else begin
      dcl_o <= en_i && dcl_d;
      fsc_o <= en_i && fsc_i;
    end
  end

endmodule

// File: rtl/fclk_frame_gen.sv
module fclk_frame_gen
  import fclk_pkg::*;
#(
  parameter int unsigned PERIODS      = 192,
  parameter int unsigned SHORT_STRIDE = 13,
  parameter int unsigned LOW_HT       = 8,
  parameter int unsigned LONG_HI_HT   = 9,
  parameter int unsigned SHORT_HI_HT  = 8,
  parameter int unsigned FSC_HT       = 537,
  parameter int unsigned ADJ_HT       = 2,
  parameter int unsigned ADJ_FRAMES   = 12,
  localparam int unsigned PER_W = $clog2(PERIODS)
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic [2:0]  mode_i,
  input  logic        ext_req_i,
  input  logic        red_req_i,
  output logic        dcl_o,
  output logic        fsc_o,
  output logic        ext_clr_o,
  output logic        red_clr_o
);

  logic             en;
  adj_dir_e         dir;
  logic [PER_W-1:0] per;
  logic             hi, fsc_raw, frame_start;

  assign en = mode_on(mode_i);

  fclk_timebase #(
    .PERIODS      (PERIODS),
    .SHORT_STRIDE (SHORT_STRIDE),
    .LOW_HT       (LOW_HT),
    .LONG_HI_HT   (LONG_HI_HT),
    .SHORT_HI_HT  (SHORT_HI_HT),
    .FSC_HT       (FSC_HT),
    .ADJ_HT       (ADJ_HT)
  ) u_timebase (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en),
    .dir_i         (dir),
    .per_o         (per),
    .hi_o          (hi),
    .fsc_o         (fsc_raw),
    .frame_start_o (frame_start)
  );

  fclk_adjust #(
    .ADJ_FRAMES (ADJ_FRAMES)
  ) u_adjust (
    .clk_i         (clk_i),
    .rst_ni        (rst_ni),
    .en_i          (en),
    .frame_start_i (frame_start),
    .ext_req_i     (ext_req_i),
    .red_req_i     (red_req_i),
    .dir_o         (dir),
    .ext_clr_o     (ext_clr_o),
    .red_clr_o     (red_clr_o)
  );

  fclk_shaper #(
    .PER_W (PER_W)
  ) u_shaper (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .en_i   (en),
    .mode_i (mode_i),
    .per_i  (per),
    .hi_i   (hi),
    .fsc_i  (fsc_raw),
    .dcl_o  (dcl_o),
    .fsc_o  (fsc_o)
  );

endmodule

// File: rtl/fclk_frame_gen_chk.sv
module fclk_frame_gen_chk (
  input logic       clk_i,
  input logic       rst_ni,
  input logic [2:0] mode_i,
  input logic       ext_req_i,
  input logic       red_req_i,
  input logic       dcl_o,
  input logic       fsc_o,
  input logic       ext_clr_o,
  input logic       red_clr_o
);

  logic       past_q;
  logic [2:0] mode_q;
  logic [4:0] hi_run_q, lo_run_q;
  logic       off_q;

  assign off_q = (mode_q == 3'd0) || (mode_q == 3'd7);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      past_q   <= 1'b0;
      mode_q   <= 3'd0;
      hi_run_q <= '0;
      lo_run_q <= '0;
    end else begin
      past_q   <= 1'b1;
      mode_q   <= mode_i;
      hi_run_q <= (mode_q != 3'd1 || !dcl_o) ? 5'd0
                : (hi_run_q == 5'd31 ? hi_run_q : hi_run_q + 5'd1);
      lo_run_q <= (mode_q != 3'd1 || dcl_o) ? 5'd0
                : (lo_run_q == 5'd31 ? lo_run_q : lo_run_q + 5'd1);
    end
  end

  assert_off_quiet_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && off_q) |-> (!dcl_o && !fsc_o && !ext_clr_o && !red_clr_o));

  assert_high_len_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd1 && dcl_o) |-> (hi_run_q < 5'd9));

  // longest low phase is the stretched last one
  assert_low_len_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q == 3'd1 && !dcl_o) |-> (lo_run_q < 5'd10));

  assert_sync_on_edge_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && $rose(fsc_o)) |-> dcl_o);

  assert_ext_clr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ext_clr_o |=> !ext_clr_o);

  assert_red_clr_pulse_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    red_clr_o |=> !red_clr_o);

  assert_clr_at_frame_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && (ext_clr_o || red_clr_o)) |-> $rose(fsc_o));

  assert_ext_clr_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && ext_clr_o) |-> $past(ext_req_i));

  assert_red_clr_cause_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (past_q && red_clr_o) |-> $past(red_req_i));

endmodule

bind fclk_frame_gen fclk_frame_gen_chk u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .mode_i    (mode_i),
  .ext_req_i (ext_req_i),
  .red_req_i (red_req_i),
  .dcl_o     (dcl_o),
  .fsc_o     (fsc_o),
  .ext_clr_o (ext_clr_o),
  .red_clr_o (red_clr_o)
);

// File: tb/sim_fclk_frame_gen.sv
`timescale 1ns/1ps
module sim_fclk_frame_gen;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] mode = 3'd0;
  logic       ext_req = 1'b0;
  logic       red_req = 1'b0;
  logic       dcl_o, fsc_o, ext_clr_o, red_clr_o;

  int checks = 0;
  int fails  = 0;
  bit run_cmp = 1'b0;
  bit done = 1'b0;
  string cur_req = "R1";

  always #5 clk = ~clk;

  fclk_frame_gen u0 (
    .clk_i     (clk),
    .rst_ni    (rst_n),
    .mode_i    (mode),
    .ext_req_i (ext_req),
    .red_req_i (red_req),
    .dcl_o     (dcl_o),
    .fsc_o     (fsc_o),
    .ext_clr_o (ext_clr_o),
    .red_clr_o (red_clr_o)
  );

  task automatic chk(string req, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
    end
  endtask

  function automatic int div_of(logic [2:0] m);
    case (m)
      3'd1: return 1;
      3'd2: return 2;
      3'd3: return 3;
      3'd4: return 4;
      3'd5: return 6;
      3'd6: return 12;
      default: return 0;
    endcase
  endfunction

  // behavioural reference, one step per tick
  int m_pos, m_per, m_tick, m_dir, m_left;
  bit e_dcl, e_fsc, e_ext, e_red;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_pos = 0; m_per = 0; m_tick = 0; m_dir = 0; m_left = 0;
      e_dcl = 0; e_fsc = 0; e_ext = 0; e_red = 0;
    end else begin
      int n, hi, len;
      n = div_of(mode);
      e_ext = 0; e_red = 0;
      if (n == 0) begin
        m_pos = 0; m_per = 0; m_tick = 0; m_dir = 0; m_left = 0;
        e_dcl = 0; e_fsc = 0;
      end else begin
        hi = ((m_per % 13) == 12) ? 8 : 9;
        e_dcl = (n == 1) ? (m_pos < hi) : ((m_per % n) < (n + 1) / 2);
        e_fsc = (m_tick < 537);
        if (m_tick == 0) begin
          if (m_dir != 0) begin
            if (m_left == 0) begin
              e_ext = (m_dir == 1); e_red = (m_dir == 2); m_dir = 0;
            end else m_left--;
          end else if (ext_req && red_req) begin
            e_ext = 1; e_red = 1;
          end else if (ext_req) begin
            m_dir = 1; m_left = 11;
          end else if (red_req) begin
            m_dir = 2; m_left = 11;
          end
        end
        len = hi + 8;
        if (m_per == 191) len += (m_dir == 1) ? 2 : ((m_dir == 2) ? -2 : 0);
        m_pos++; m_tick++;
        if (m_pos == len) begin
          m_pos = 0; m_per++;
          if (m_per == 192) begin m_per = 0; m_tick = 0; end
        end
      end
    end
  end

  always @(negedge clk) begin
    if (rst_n && run_cmp && !done) begin
      chk(cur_req, "dcl_o", dcl_o, e_dcl);
      chk(cur_req, "fsc_o", fsc_o, e_fsc);
      chk(cur_req, "ext_clr_o", ext_clr_o, e_ext);
      chk(cur_req, "red_clr_o", red_clr_o, e_red);
    end
  end

  task automatic sync_frame();
    logic p;
    p = fsc_o;
    forever begin
      @(negedge clk);
      if (fsc_o && !p) break;
      p = fsc_o;
    end
  endtask

  // call on the tick-0 sample; returns at the next tick-0 sample
  task automatic measure(output int len, output int rises, output int fh,
                         output int ce, output int cr);
    logic pf, pd;
    len = 1; rises = dcl_o ? 1 : 0; fh = fsc_o ? 1 : 0;
    ce = ext_clr_o ? 1 : 0; cr = red_clr_o ? 1 : 0;
    if (ext_clr_o) ext_req = 1'b0;
    if (red_clr_o) red_req = 1'b0;
    pf = fsc_o; pd = dcl_o;
    forever begin
      @(negedge clk);
      if (fsc_o && !pf) break;
      len++;
      if (dcl_o && !pd) rises++;
      if (fsc_o) fh++;
      if (ext_clr_o) begin ce++; ext_req = 1'b0; end
      if (red_clr_o) begin cr++; red_req = 1'b0; end
      pf = fsc_o; pd = dcl_o;
    end
  endtask

  task automatic finish_run();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (195000) @(posedge clk);
    fails++;
    checks++;
    $display("FAIL watchdog: got timeout expected completion");
    finish_run();
  end

  initial begin
    int len, rises, fh, ce, cr;
    // R1: reset and off modes
    repeat (3) @(negedge clk);
    chk("R1", "reset dcl_o", dcl_o, 0);
    chk("R1", "reset fsc_o", fsc_o, 0);
    chk("R1", "reset ext_clr_o", ext_clr_o, 0);
    rst_n = 1'b1;
    run_cmp = 1'b1;
    ext_req = 1'b1;
    repeat (8) @(negedge clk);
    chk("R1", "off dcl_o", dcl_o, 0);
    chk("R1", "off ext_clr_o", ext_clr_o, 0);
    ext_req = 1'b0;

    // R4: enable latency
    cur_req = "R4";
    mode = 3'd1;
    @(negedge clk);
    chk("R4", "first fsc_o", fsc_o, 1);
    chk("R4", "first dcl_o", dcl_o, 1);

    // R2 and R3: base frame
    cur_req = "R2";
    measure(len, rises, fh, ce, cr);
    chk("R3", "frame length", len, 3250);
    chk("R3", "sync width", fh, 537);
    chk("R2", "edges per frame", rises, 192);
    measure(len, rises, fh, ce, cr);
    chk("R3", "second frame length", len, 3250);

    // R5: extend
    cur_req = "R5";
    ext_req = 1'b1;
    measure(len, rises, fh, ce, cr);
    chk("R5", "frame before sampling", len, 3250);
    for (int i = 0; i < 12; i++) begin
      measure(len, rises, fh, ce, cr);
      chk("R5", "extended frame", len, 3252);
      chk("R5", "no early clear", ce, 0);
    end
    cur_req = "R7";
    measure(len, rises, fh, ce, cr);
    chk("R7", "ext clear count", ce, 1);
    chk("R7", "frame after extend", len, 3250);

    // R6: reduce
    cur_req = "R6";
    red_req = 1'b1;
    measure(len, rises, fh, ce, cr);
    chk("R6", "frame before sampling", len, 3250);
    for (int i = 0; i < 12; i++) begin
      measure(len, rises, fh, ce, cr);
      chk("R6", "reduced frame", len, 3248);
      chk("R6", "no early clear", cr, 0);
    end
    cur_req = "R7";
    measure(len, rises, fh, ce, cr);
    chk("R7", "red clear count", cr, 1);
    chk("R7", "frame after reduce", len, 3250);

    // R8: conflicting requests
    cur_req = "R8";
    ext_req = 1'b1; red_req = 1'b1;
    measure(len, rises, fh, ce, cr);
    measure(len, rises, fh, ce, cr);
    chk("R8", "ext clear", ce, 1);
    chk("R8", "red clear", cr, 1);
    chk("R8", "frame unchanged", len, 3250);
    measure(len, rises, fh, ce, cr);
    chk("R8", "following frame", len, 3250);

    // R9: divided modes
    cur_req = "R9";
    for (int m = 2; m <= 6; m++) begin
      mode = 3'(m);
      measure(len, rises, fh, ce, cr);
      chk("R9", "frame length", len, 3250);
      chk("R9", "sync width", fh, 537);
      chk("R9", "edges per frame", rises, 192 / div_of(3'(m)));
    end

    // R1: code 7 is off
    cur_req = "R1";
    mode = 3'd7;
    repeat (6) @(negedge clk);
    chk("R1", "mode 7 dcl_o", dcl_o, 0);
    chk("R1", "mode 7 fsc_o", fsc_o, 0);

    // R10: disable during adjustment
    cur_req = "R10";
    mode = 3'd1;
    @(negedge clk);
    ext_req = 1'b1;
    measure(len, rises, fh, ce, cr);
    repeat (1000) @(negedge clk);
    mode = 3'd0;
    repeat (20) @(negedge clk);
    chk("R10", "off dcl_o", dcl_o, 0);
    chk("R10", "off ext_clr_o", ext_clr_o, 0);
    ext_req = 1'b0;
    mode = 3'd1;
    @(negedge clk);
    chk("R10", "restart fsc_o", fsc_o, 1);
    measure(len, rises, fh, ce, cr);
    chk("R10", "nominal after restart", len, 3250);
    chk("R10", "no clear after abort", ce, 0);

    finish_run();
  end

endmodule